// File: doc/BRIEF.md
# Home directory coherence controller

This block is the home-node side of a directory-based cache coherence scheme for a small bank of memory blocks shared by several processor nodes. Every block has a directory entry: a protocol state, a sharer bit vector with one bit per node, an owner id, and the identity of a request that is waiting. The controller takes one protocol message per cycle from an input port and produces at most one protocol message per cycle on an output port. Each message carries a node id, a message code, a block address and a data byte.

Read requests are served from the local memory array while a block is in the shared state. An ownership request first removes every other copy: invalidations go out one per cycle, and the grant is sent only when the last acknowledgement is back. A request to a block that a node holds modified recalls the line with a write-back or flush command. The returned data is written into memory, and the waiting request is then completed. A request that reaches a block in a transient state is parked in a single holding slot and replayed once that block settles.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset every block is shared with an empty sharer set, memory block i holds (17*i+3) mod 2^DATA_W, in_ready is 1 and out_valid is 0.
- R2: Message codes. Inbound: 1 read request, 2 ownership request, 3 invalidation acknowledge, 4 write-back data, 5 flush data. Outbound: 8 read grant, 9 ownership grant, 10 invalidate, 11 write-back command, 12 flush command. Commands carry data 0, and out_valid never shows any other code.
- R3: A read request to a shared block adds the requester to the sharers, and in the cycle after acceptance it returns a read grant to the requester with the block's memory data.
- R4: An ownership request to a shared block that has no sharer other than the requester returns an ownership grant with memory data in the cycle after acceptance, and the requester becomes the owner.
- R5: An ownership request to a shared block with other sharers issues one invalidate per other sharer, in ascending node id, one per cycle, starting two cycles after acceptance; in_ready stays 0 while they are issued.
- R6: In the acknowledge-wait state each acknowledge removes its sender from the sharers. The acknowledge that empties the set produces an ownership grant with memory data to the requester, and the block becomes owned by the requester.
- R7: A read request to an owned block sends a write-back command to the owner, and an ownership request sends a flush command to the owner; the block then waits for data.
- R8: Write-back data from the owner while waiting updates memory, sends a read grant with that data to the waiting node, and leaves the block shared by both the old owner and the waiting node.
- R9: Flush data from the owner while waiting updates memory, sends an ownership grant with that data to the waiting node, and makes that node the owner.
- R10: A request to a block in a transient state is held in a one-entry slot with no output. It is replayed ahead of new input as soon as the block is stable. While the slot is full, a further request to a transient block sees in_ready 0.
- R11: Acknowledge, write-back data or flush data that does not match the block's waiting state is ignored: no output and no change to memory or directory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inbound message present |
| in_ready | output | 1 | Inbound message accepted on this edge |
| in_src | input | ID_W | Sending node id |
| in_type | input | 4 | Inbound message code |
| in_addr | input | ADDR_W | Block address |
| in_data | input | DATA_W | Returned line data |
| out_valid | output | 1 | Outbound message present |
| out_dst | output | ID_W | Destination node id |
| out_type | output | 4 | Outbound message code |
| out_addr | output | ADDR_W | Block address |
| out_data | output | DATA_W | Line data for grants, 0 for commands |

## Verification
Reads are tried on a block with no sharers and on one with several sharers, which shows that grants depend only on the memory contents and not on the sharer set. Ownership requests are tried with no other sharer, with only the requester sharing, with two other sharers, and with three, which separates an immediate grant from an invalidation walk and checks the order of the walk. Recalls are tried with both write-back and flush data, followed by a request from a third node whose invalidate targets show the sharer set that was left behind. Stray replies, a parked request and a request refused for a full slot show that unmatched traffic has no effect and that replay is ordered correctly.

// File: rtl/hdc_pkg.sv
package hdc_pkg;
  localparam logic [3:0] MSG_REQ_READ  = 4'h1;
  localparam logic [3:0] MSG_REQ_OWN   = 4'h2;
  localparam logic [3:0] MSG_ACK_INVAL = 4'h3;
  localparam logic [3:0] MSG_RET_WB    = 4'h4;
  localparam logic [3:0] MSG_RET_FLUSH = 4'h5;
  localparam logic [3:0] MSG_RSP_READ  = 4'h8;
  localparam logic [3:0] MSG_RSP_OWN   = 4'h9;
  localparam logic [3:0] MSG_CMD_INVAL = 4'hA;
  localparam logic [3:0] MSG_CMD_WB    = 4'hB;
  localparam logic [3:0] MSG_CMD_FLUSH = 4'hC;

  typedef enum logic [1:0] {
    DS_SHARED    = 2'd0,
    DS_OWNED     = 2'd1,
    DS_WAIT_ACK  = 2'd2,
    DS_WAIT_DATA = 2'd3
  } dir_state_e;
endpackage

// File: rtl/hdc_block_store.sv
module hdc_block_store
  import hdc_pkg::*;
#(
  parameter int N_NODES  = 4,
  parameter int N_BLOCKS = 4,
  parameter int DATA_W   = 8,
  parameter int ID_W     = 2,
  parameter int ADDR_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  ra_addr,
  output dir_state_e         ra_st,
  output logic [N_NODES-1:0] ra_shr,
  output logic [ID_W-1:0]    ra_own,
  output logic [ID_W-1:0]    ra_rqid,
  output logic               ra_rqex,
  output logic [DATA_W-1:0]  ra_data,
  input  logic [ADDR_W-1:0]  rb_addr,
  output dir_state_e         rb_st,
  input  logic               we,
  input  logic               dwe,
  input  logic [ADDR_W-1:0]  wa,
  input  dir_state_e         w_st,
  input  logic [N_NODES-1:0] w_shr,
  input  logic [ID_W-1:0]    w_own,
  input  logic [ID_W-1:0]    w_rqid,
  input  logic               w_rqex,
  input  logic [DATA_W-1:0]  w_data
);
  dir_state_e         st_q   [N_BLOCKS];
  logic [N_NODES-1:0] shr_q  [N_BLOCKS];
  logic [ID_W-1:0]    own_q  [N_BLOCKS];
  logic [ID_W-1:0]    rqid_q [N_BLOCKS];
  logic               rqex_q [N_BLOCKS];
  logic [DATA_W-1:0]  data_q [N_BLOCKS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < N_BLOCKS; b++) begin
        st_q[b]   <= DS_SHARED;
        shr_q[b]  <= '0;
        own_q[b]  <= '0;
        rqid_q[b] <= '0;
        rqex_q[b] <= 1'b0;
        data_q[b] <= DATA_W'(b * 17 + 3);
      end
    end else begin
      for (int b = 0; b < N_BLOCKS; b++) begin
        if (we && wa == ADDR_W'(b)) begin
          st_q[b]   <= w_st;
          shr_q[b]  <= w_shr;
          own_q[b]  <= w_own;
          rqid_q[b] <= w_rqid;
          rqex_q[b] <= w_rqex;
        end
        if (dwe && wa == ADDR_W'(b)) data_q[b] <= w_data;
      end
    end
  end

  assign ra_st   = st_q[ra_addr];
  assign ra_shr  = shr_q[ra_addr];
  assign ra_own  = own_q[ra_addr];
  assign ra_rqid = rqid_q[ra_addr];
  assign ra_rqex = rqex_q[ra_addr];
  assign ra_data = data_q[ra_addr];
  assign rb_st   = st_q[rb_addr];
endmodule

// File: rtl/hdc_inval_seq.sv
module hdc_inval_seq #(
  parameter int N_NODES = 4,
  parameter int ID_W    = 2,
  parameter int ADDR_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [N_NODES-1:0] load_vec,
  input  logic [ADDR_W-1:0]  load_addr,
  output logic               busy,
  output logic [ID_W-1:0]    cur_id,
  output logic [ADDR_W-1:0]  cur_addr
);
  localparam logic [N_NODES-1:0] ONE = N_NODES'(1);

  logic [N_NODES-1:0] vec_q, vec_d;
  logic [ADDR_W-1:0]  addr_q;

  assign busy     = |vec_q;
  assign cur_addr = addr_q;

  always_comb begin
    cur_id = '0;
    for (int i = N_NODES - 1; i >= 0; i--) begin
      if (vec_q[i]) cur_id = ID_W'(i);
    end
  end

  always_comb begin
    vec_d = vec_q;
    if (load) vec_d = load_vec;
    else if (busy) vec_d = vec_q & ~(ONE << cur_id);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      addr_q <= '0;
    end else begin
      vec_q <= vec_d;
      if (load) addr_q <= load_addr;
    end
  end
endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl
  import hdc_pkg::*;
#(
  parameter int N_NODES  = 4,
  parameter int N_BLOCKS = 4,
  parameter int DATA_W   = 8,
  parameter int ID_W     = $clog2(N_NODES),
  parameter int ADDR_W   = $clog2(N_BLOCKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ID_W-1:0]   in_src,
  input  logic [3:0]        in_type,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [ID_W-1:0]   out_dst,
  output logic [3:0]        out_type,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);
  localparam logic [N_NODES-1:0] ONE = N_NODES'(1);

  dir_state_e         ra_st, rb_st, w_st;
  logic [N_NODES-1:0] ra_shr, w_shr, others, left;
  logic [ID_W-1:0]    ra_own, ra_rqid, w_own, w_rqid;
  logic               ra_rqex, w_rqex, we, dwe;
  logic [DATA_W-1:0]  ra_data;

  logic              hold_vld, hold_set;
  logic [ID_W-1:0]   hold_src;
  logic [3:0]        hold_type;
  logic [ADDR_W-1:0] hold_addr;

  logic              walk_busy, seq_load;
  logic [ID_W-1:0]   walk_id;
  logic [ADDR_W-1:0] walk_addr;

  logic              sel_hold, go, in_is_req, blk_transient;
  logic [ID_W-1:0]   cur_src;
  logic [3:0]        cur_type;
  logic [ADDR_W-1:0] cur_addr;

  logic              o_vld_d;
  logic [ID_W-1:0]   o_dst_d;
  logic [3:0]        o_type_d;
  logic [DATA_W-1:0] o_data_d;
  logic [ADDR_W-1:0] o_addr_d;

  hdc_block_store #(
    .N_NODES(N_NODES), .N_BLOCKS(N_BLOCKS), .DATA_W(DATA_W), .ID_W(ID_W), .ADDR_W(ADDR_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .ra_addr(cur_addr), .ra_st(ra_st), .ra_shr(ra_shr), .ra_own(ra_own),
    .ra_rqid(ra_rqid), .ra_rqex(ra_rqex), .ra_data(ra_data),
    .rb_addr(hold_addr), .rb_st(rb_st),
    .we(we), .dwe(dwe), .wa(cur_addr), .w_st(w_st), .w_shr(w_shr),
    .w_own(w_own), .w_rqid(w_rqid), .w_rqex(w_rqex), .w_data(in_data)
  );

  hdc_inval_seq #(.N_NODES(N_NODES), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(seq_load), .load_vec(others), .load_addr(cur_addr),
    .busy(walk_busy), .cur_id(walk_id), .cur_addr(walk_addr)
  );

  // A parked request replays once its block is stable; it beats new input.
  assign sel_hold = !walk_busy && hold_vld && (rb_st == DS_SHARED || rb_st == DS_OWNED);
  assign cur_src  = sel_hold ? hold_src  : in_src;
  assign cur_type = sel_hold ? hold_type : in_type;
  assign cur_addr = sel_hold ? hold_addr : in_addr;

  assign in_is_req     = (in_type == MSG_REQ_READ) || (in_type == MSG_REQ_OWN);
  assign blk_transient = (ra_st == DS_WAIT_ACK) || (ra_st == DS_WAIT_DATA);
  assign in_ready      = !walk_busy && !sel_hold && !(in_is_req && hold_vld && blk_transient);
  assign go            = !walk_busy && (sel_hold || (in_valid && in_ready));

  assign others = ra_shr & ~(ONE << cur_src);
  assign left   = ra_shr & ~(ONE << cur_src);

  always_comb begin
    we = 1'b0; dwe = 1'b0; hold_set = 1'b0; seq_load = 1'b0;
    w_st = ra_st; w_shr = ra_shr; w_own = ra_own; w_rqid = ra_rqid; w_rqex = ra_rqex;
    o_vld_d = 1'b0; o_dst_d = cur_src; o_type_d = MSG_RSP_READ;
    o_addr_d = cur_addr; o_data_d = '0;
    if (walk_busy) begin
      o_vld_d = 1'b1; o_dst_d = walk_id; o_type_d = MSG_CMD_INVAL; o_addr_d = walk_addr;
    end else if (go) begin
      case (cur_type)
        MSG_REQ_READ, MSG_REQ_OWN: begin
          if (ra_st == DS_SHARED && cur_type == MSG_REQ_READ) begin
            we = 1'b1; w_shr = ra_shr | (ONE << cur_src);
            o_vld_d = 1'b1; o_data_d = ra_data;
          end else if (ra_st == DS_SHARED && others == '0) begin
            we = 1'b1; w_st = DS_OWNED; w_own = cur_src; w_shr = '0;
            o_vld_d = 1'b1; o_type_d = MSG_RSP_OWN; o_data_d = ra_data;
          end else if (ra_st == DS_SHARED) begin
            we = 1'b1; w_st = DS_WAIT_ACK; w_own = cur_src; w_shr = others;
            seq_load = 1'b1;
          end else if (ra_st == DS_OWNED) begin
            we = 1'b1; w_st = DS_WAIT_DATA; w_rqid = cur_src;
            w_rqex = (cur_type == MSG_REQ_OWN);
            o_vld_d = 1'b1; o_dst_d = ra_own;
            o_type_d = (cur_type == MSG_REQ_OWN) ? MSG_CMD_FLUSH : MSG_CMD_WB;
          end else begin
            hold_set = 1'b1;
          end
        end
        MSG_ACK_INVAL: begin
          if (ra_st == DS_WAIT_ACK) begin
            we = 1'b1; w_shr = left;
            if (left == '0) begin
              w_st = DS_OWNED;
              o_vld_d = 1'b1; o_dst_d = ra_own; o_type_d = MSG_RSP_OWN; o_data_d = ra_data;
            end
          end
        end
        MSG_RET_WB, MSG_RET_FLUSH: begin
          if (ra_st == DS_WAIT_DATA && cur_src == ra_own &&
              ra_rqex == (cur_type == MSG_RET_FLUSH)) begin
            we = 1'b1; dwe = 1'b1;
            o_vld_d = 1'b1; o_dst_d = ra_rqid; o_data_d = in_data;
            if (ra_rqex) begin
              w_st = DS_OWNED; w_own = ra_rqid; w_shr = '0; o_type_d = MSG_RSP_OWN;
            end else begin
              w_st = DS_SHARED; w_shr = (ONE << ra_own) | (ONE << ra_rqid);
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld <= 1'b0; hold_src <= '0; hold_type <= '0; hold_addr <= '0;
    end else begin
      if (sel_hold) hold_vld <= 1'b0;
      else if (hold_set) hold_vld <= 1'b1;
      if (hold_set) begin
        hold_src <= in_src; hold_type <= in_type; hold_addr <= in_addr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_dst <= '0; out_type <= '0; out_addr <= '0; out_data <= '0;
    end else begin
      out_valid <= o_vld_d;
      if (o_vld_d) begin
        out_dst <= o_dst_d; out_type <= o_type_d; out_addr <= o_addr_d; out_data <= o_data_d;
      end
    end
  end
endmodule

// File: rtl/hdc_checker.sv
module hdc_checker
  import hdc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [3:0] in_type,
  input logic       out_valid,
  input logic [3:0] out_type,
  input logic       walk_busy,
  input logic       sel_hold
);
  AST_OUT_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_type >= MSG_RSP_READ && out_type <= MSG_CMD_FLUSH)); // R2

  AST_WALK_EMITS_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
    walk_busy |=> (out_valid && out_type == MSG_CMD_INVAL)); // R5

  AST_WALK_STALLS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    walk_busy |-> !in_ready); // R5

  AST_REPLY_NEVER_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_type >= MSG_ACK_INVAL && in_type <= MSG_RET_FLUSH
     && !walk_busy && !sel_hold) |-> in_ready); // R10

  AST_REPLAY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hold |-> !in_ready); // R10

  always @(posedge clk) begin
    if (!rst_n) AST_RESET_QUIET: assert (!out_valid); // R1
  end
endmodule

bind home_dir_ctrl hdc_checker u_hdc_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_type(in_type),
  .out_valid(out_valid), .out_type(out_type), .walk_busy(walk_busy), .sel_hold(sel_hold)
);

// File: tb/home_dir_ctrl_bench.sv
`timescale 1ns/1ps
module home_dir_ctrl_bench;
  localparam logic [3:0] RQR = 4'h1, RQO = 4'h2, ACK = 4'h3, RWB = 4'h4, RFL = 4'h5;
  localparam logic [3:0] GRD = 4'h8, GOW = 4'h9, INV = 4'hA, CWB = 4'hB, CFL = 4'hC;

  logic       clk, rst_n, in_valid, in_ready, out_valid;
  logic [1:0] in_src, in_addr, out_dst, out_addr;
  logic [3:0] in_type, out_type;
  logic [7:0] in_data, out_data;

  typedef struct packed { logic [1:0] dst; logic [3:0] typ; logic [1:0] addr; logic [7:0] data; } item_t;
  item_t exp_q[$];
  int n_chk = 0, n_fail = 0, n_out = 0;

  home_dir_ctrl u_home_dir_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_src(in_src),
    .in_type(in_type), .in_addr(in_addr), .in_data(in_data), .out_valid(out_valid),
    .out_dst(out_dst), .out_type(out_type), .out_addr(out_addr), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_msg(input int dst, input logic [3:0] t, input int a, input int d);
    exp_q.push_back(item_t'{dst[1:0], t, a[1:0], d[7:0]});
  endtask

  task automatic send(input int src, input logic [3:0] t, input int a, input int d);
    @(negedge clk);
    in_valid = 1'b1; in_src = src[1:0]; in_type = t; in_addr = a[1:0]; in_data = d[7:0];
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: every produced message is compared against the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      n_out++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 unexpected output", int'({out_dst, out_type, out_addr, out_data}), 0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        chk({out_dst, out_type, out_addr, out_data} == e, "R2 output message",
            int'({out_dst, out_type, out_addr, out_data}), int'(e));
      end
    end
  end

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0; in_valid = 1'b0; in_src = '0; in_type = '0; in_addr = '0; in_data = '0;
    idle(3);
    #1;
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    // R3: reads to block 0 (reset data 3), building sharers {1,2,3}
    expect_msg(1, GRD, 0, 3); send(1, RQR, 0, 0);
    expect_msg(2, GRD, 0, 3); send(2, RQR, 0, 0);
    expect_msg(3, GRD, 0, 3); send(3, RQR, 0, 0);
    idle(3);

    // R5: node 2 asks for ownership, invalidates go to 1 then 3
    expect_msg(1, INV, 0, 0); expect_msg(3, INV, 0, 0);
    send(2, RQO, 0, 0);
    #1 chk(in_ready == 1'b0, "R5 input stalled during walk", in_ready, 0);
    idle(4);

    // R6: first acknowledge silent, last one grants
    base = n_out;
    send(3, ACK, 0, 0); idle(3);
    chk(n_out == base, "R6 partial acknowledge silent", n_out - base, 0);
    expect_msg(2, GOW, 0, 3); send(1, ACK, 0, 0); idle(3);

    // R7/R9: flush recall then flush data
    expect_msg(2, CFL, 0, 0); send(0, RQO, 0, 0); idle(2);
    expect_msg(0, GOW, 0, 8'h5A); send(2, RFL, 0, 8'h5A); idle(3);

    // R7/R10/R8: write-back recall, parked request, write-back data, replay
    expect_msg(0, CWB, 0, 0); send(1, RQR, 0, 0); idle(2);
    base = n_out;
    send(3, RQR, 0, 0); idle(3);
    chk(n_out == base, "R10 parked request silent", n_out - base, 0);
    expect_msg(1, GRD, 0, 8'h77); expect_msg(3, GRD, 0, 8'h77);
    send(0, RWB, 0, 8'h77); idle(4);

    // R8: sharer set {0,1,3} revealed by invalidate targets
    expect_msg(0, INV, 0, 0); expect_msg(1, INV, 0, 0); expect_msg(3, INV, 0, 0);
    send(2, RQO, 0, 0); idle(5);
    send(0, ACK, 0, 0); send(1, ACK, 0, 0);
    expect_msg(2, GOW, 0, 8'h77); send(3, ACK, 0, 0); idle(3);

    // R11: stray replies on block 1 change nothing
    base = n_out;
    send(1, ACK, 1, 0); send(1, RWB, 1, 8'hEE); send(1, RFL, 1, 8'hEE); idle(3);
    chk(n_out == base, "R11 stray replies silent", n_out - base, 0);
    expect_msg(1, GRD, 1, 20); send(1, RQR, 1, 0); idle(2);
    // R4: only the requester shares block 1
    expect_msg(1, GOW, 1, 20); send(1, RQO, 1, 0); idle(2);
    // R4: uncached block 2 (reset data 37)
    expect_msg(0, GOW, 2, 37); send(0, RQO, 2, 0); idle(2);

    // R10: slot full, a further request to a transient block is refused
    expect_msg(0, CWB, 2, 0); send(1, RQR, 2, 0); idle(2);
    send(2, RQR, 2, 0); idle(2);
    @(negedge clk);
    in_valid = 1'b1; in_src = 2'd3; in_type = RQO; in_addr = 2'd2;
    #1 chk(in_ready == 1'b0, "R10 full slot refuses request", in_ready, 0);
    idle(3);
    #1 chk(in_ready == 1'b0, "R10 refusal persists", in_ready, 0);
    in_valid = 1'b0;
    expect_msg(1, GRD, 2, 8'h42); expect_msg(2, GRD, 2, 8'h42);
    send(0, RWB, 2, 8'h42); idle(4);
    expect_msg(0, INV, 2, 0); expect_msg(1, INV, 2, 0); expect_msg(2, INV, 2, 0);
    send(3, RQO, 2, 0); idle(5);
    send(0, ACK, 2, 0); send(1, ACK, 2, 0);
    expect_msg(3, GOW, 2, 8'h42); send(2, ACK, 2, 0); idle(4);

    chk(exp_q.size() == 0, "R2 all expected messages produced", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule